// File: doc/BRIEF.md
# SPI Master Transfer Engine with Chip-Select Setup and Hold Delays

The block runs single-word SPI transfers as a bus master. A one-cycle start request loads a 32-bit configuration word and a transmit word. The engine then pulls its chip select low and waits a programmable setup time before it makes the first SCK edge. It shifts 4 to 16 bits in both directions, and after the last SCK edge it waits a separate programmable hold time before it releases chip select. The setup and hold times are each an odd prescaler (1, 3, 5 or 7) times a power-of-two scaler. This lets slow devices that need a minimum gap between select and clock be served without lowering the bit rate.

The configuration word also sets the frame length, the SCK idle level, the sampling phase, the bit order and the SCK half-period. The half-period is a prime prescaler (2, 3, 5 or 7) times a power-of-two scaler. The configuration is held for the whole transfer, so the host may change its inputs as soon as the transfer has started. A one-cycle done pulse marks the release of chip select. The received word stays on the receive port until the next transfer starts.

Top module: `spi_cs_delay_master`

## Requirements
- R1: After reset, cs_no is high, sck_o is low, busy_o is low and done_o is low.
- R2: When start_i is high and busy_o is low at a clock edge, cs_no goes low and busy_o goes high at that edge. At the same edge sck_o takes the idle level given by cfg_i bit 26 (0 means idle low).
- R3: The first SCK edge comes exactly L = P·2^(n+1) clock cycles after cs_no falls. P is 1, 3, 5 or 7 for code 0 to 3 in cfg_i[23:22], and n is cfg_i[15:12].
- R4: cs_no rises exactly T = P·2^(n+1) cycles after the last SCK edge. P is 1, 3, 5 or 7 for code 0 to 3 in cfg_i[21:20], and n is cfg_i[11:8].
- R5: Consecutive SCK edges are exactly H = B·2^(n+1) cycles apart. B is 2, 3, 5 or 7 for code 0 to 3 in cfg_i[17:16], and n is cfg_i[3:0].
- R6: Frame code c in cfg_i[30:27] selects c+1 bits, and codes 0 to 2 select 4 bits. A transfer makes exactly twice that many SCK edges and leaves sck_o at its idle level.
- R7: With cfg_i bit 25 clear, the first bit is on mosi_o from the fall of cs_no, MISO is captured on odd-numbered SCK edges and MOSI advances on even-numbered edges. With bit 25 set, MOSI advances on odd edges and MISO is captured on even edges.
- R8: With cfg_i bit 24 set, bit 0 of the word goes first. With it clear, bit (bits−1) goes first. rx_data_o is right-aligned and its bits above the frame are zero.
- R9: done_o is high for exactly one cycle, in the cycle where cs_no rises and busy_o falls. From then until the next start, rx_data_o holds the received word.
- R10: While busy_o is high, start_i, cfg_i and tx_data_i have no effect. The transfer runs with the values latched at its start, and no second transfer follows.
- R11: sck_o changes only while cs_no is low, or in the cycle where cs_no falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Transfer request, accepted while not busy |
| cfg_i | input | 32 | Configuration word, latched at start |
| tx_data_i | input | 16 | Transmit word, right-aligned |
| miso_i | input | 1 | Serial data from the slave |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle pulse when chip select releases |
| rx_data_o | output | 16 | Received word, right-aligned |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to the slave |
| cs_no | output | 1 | Chip select, active low |

## Verification
The checker assumes that reset is low from time zero and that start_i is sampled synchronously. It relies on the shortest setup delay being two cycles, which holds for every code, so sck_o cannot move in the cycle right after chip select falls. The bench drives every input at falling clock edges. Its slave model changes miso_i only in the cycle after an SCK edge has been seen, which leaves at least one full cycle before the next capture edge. Random delay and baud codes are kept small to bound run time, and a few directed runs reach the larger scaler values.

// File: rtl/spi_cd_pkg.sv
package spi_cd_pkg;
  localparam int MAX_BITS = 16;
  localparam int PRE_W    = 2;
  localparam int SC_W     = 4;
  localparam int CNT_W    = 3 + (1 << SC_W);
  localparam int EDGE_W   = $clog2(2 * MAX_BITS + 1);
  localparam int BIT_W    = $clog2(MAX_BITS + 1);
  localparam int IDX_W    = $clog2(MAX_BITS);

  typedef enum logic [1:0] {ST_IDLE, ST_LEAD, ST_XFER, ST_TRAIL} st_e;

  typedef struct packed {
    logic [3:0]       fsz;
    logic             cpol;
    logic             cpha;
    logic             lsb;
    logic [PRE_W-1:0] lead_pre;
    logic [PRE_W-1:0] trail_pre;
    logic [PRE_W-1:0] baud_pre;
    logic [SC_W-1:0]  lead_sc;
    logic [SC_W-1:0]  trail_sc;
    logic [SC_W-1:0]  baud_sc;
  } cfg_t;

  function automatic cfg_t cfg_decode(input logic [31:0] w);
    cfg_t c;
    c.fsz       = w[30:27];
    c.cpol      = w[26];
    c.cpha      = w[25];
    c.lsb       = w[24];
    c.lead_pre  = w[23:22];
    c.trail_pre = w[21:20];
    c.baud_pre  = w[17:16];
    c.lead_sc   = w[15:12];
    c.trail_sc  = w[11:8];
    c.baud_sc   = w[3:0];
    return c;
  endfunction
endpackage

// File: rtl/spi_cd_scale.sv
module spi_cd_scale #(
  parameter int PRE_W = 2,
  parameter int SC_W  = 4,
  parameter int CNT_W = 19,
  parameter bit PRIME = 1'b0
) (
  input  logic [PRE_W-1:0] pre_i,
  input  logic [SC_W-1:0]  sc_i,
  output logic [CNT_W-1:0] cyc_o
);
  logic [2:0]    fac;
  logic [SC_W:0] shamt;

  generate
    if (PRIME) begin : g_prime
      always_comb begin
        case (pre_i)
          2'd0:    fac = 3'd2;
          2'd1:    fac = 3'd3;
          2'd2:    fac = 3'd5;
          default: fac = 3'd7;
        endcase
      end
    end else begin : g_odd
      assign fac = {pre_i, 1'b1};
    end
  endgenerate

  assign shamt = {1'b0, sc_i} + (SC_W+1)'(1);
  assign cyc_o = CNT_W'(fac) << shamt;
endmodule

// File: rtl/spi_cd_timer.sv
module spi_cd_timer
  import spi_cd_pkg::*;
#(
  parameter int CNT_W  = 19,
  parameter int EDGE_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic              cpol_i,
  input  logic [CNT_W-1:0]  lead_i,
  input  logic [CNT_W-1:0]  trail_i,
  input  logic [CNT_W-1:0]  half_i,
  input  logic [EDGE_W-1:0] edges_i,
  output logic              cs_n_o,
  output logic              sck_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              edge_o,
  output logic [EDGE_W-1:0] edge_num_o
);
  st_e               st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [EDGE_W-1:0] ecnt_q;
  logic              cnt_zero;

  assign cnt_zero   = (cnt_q == '0);
  assign busy_o     = (st_q != ST_IDLE);
  assign edge_o     = cnt_zero && ((st_q == ST_LEAD) || (st_q == ST_XFER));
  assign edge_num_o = ecnt_q + EDGE_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      ecnt_q <= '0;
      sck_o  <= 1'b0;
      cs_n_o <= 1'b1;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (st_q)
        ST_IDLE: if (go_i) begin
          st_q   <= ST_LEAD;
          cs_n_o <= 1'b0;
          sck_o  <= cpol_i;
          cnt_q  <= lead_i - CNT_W'(1);
          ecnt_q <= '0;
        end
        ST_LEAD: if (cnt_zero) begin
          st_q   <= ST_XFER;
          sck_o  <= ~sck_o;
          ecnt_q <= EDGE_W'(1);
          cnt_q  <= half_i - CNT_W'(1);
        end else begin
          cnt_q <= cnt_q - CNT_W'(1);
        end
        ST_XFER: if (cnt_zero) begin
          sck_o  <= ~sck_o;
          ecnt_q <= edge_num_o;
          if (edge_num_o == edges_i) begin
            st_q  <= ST_TRAIL;
            cnt_q <= trail_i - CNT_W'(1);
          end else begin
            cnt_q <= half_i - CNT_W'(1);
          end
        end else begin
          cnt_q <= cnt_q - CNT_W'(1);
        end
        default: if (cnt_zero) begin
          st_q   <= ST_IDLE;
          cs_n_o <= 1'b1;
          done_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q - CNT_W'(1);
        end
      endcase
    end
  end
endmodule

// File: rtl/spi_cd_shift.sv
module spi_cd_shift #(
  parameter int DATA_W = 16,
  parameter int EDGE_W = 6,
  parameter int BIT_W  = 5,
  parameter int IDX_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] tx_i,
  input  logic [BIT_W-1:0]  nbits_i,
  input  logic              cpha_i,
  input  logic              lsb_i,
  input  logic              edge_i,
  input  logic [EDGE_W-1:0] edge_num_i,
  input  logic              miso_i,
  output logic              mosi_o,
  output logic [DATA_W-1:0] rx_o
);
  logic [DATA_W-1:0] tx_q, rx_q;
  logic [BIT_W-1:0]  k_q, k_nxt, j_smp;
  logic [EDGE_W-1:0] half_e;
  logic              smp, adv;

  function automatic logic [IDX_W-1:0] bit_pos(input logic [BIT_W-1:0] b,
                                              input logic lsb,
                                              input logic [BIT_W-1:0] n);
    logic [BIT_W-1:0] p;
    p = lsb ? b : (n - BIT_W'(1) - b);
    return p[IDX_W-1:0];
  endfunction

  // edge e: sample slot and shift slot both derive from (e-1)>>1
  assign half_e = (edge_num_i - EDGE_W'(1)) >> 1;
  assign j_smp  = half_e[BIT_W-1:0];
  assign k_nxt  = cpha_i ? j_smp : j_smp + BIT_W'(1);
  assign smp    = edge_i && (edge_num_i[0] ^ cpha_i);
  assign adv    = edge_i && (edge_num_i[0] == cpha_i) && (k_nxt < nbits_i);

  assign mosi_o = tx_q[bit_pos(k_q, lsb_i, nbits_i)];
  assign rx_o   = rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q <= '0;
      rx_q <= '0;
      k_q  <= '0;
    end else if (load_i) begin
      tx_q <= tx_i;
      rx_q <= '0;
      k_q  <= '0;
    end else begin
      if (smp) rx_q[bit_pos(j_smp, lsb_i, nbits_i)] <= miso_i;
      if (adv) k_q <= k_nxt;
    end
  end
endmodule

// File: rtl/spi_cs_delay_master.sv
module spi_cs_delay_master
  import spi_cd_pkg::*;
#(
  parameter int DATA_W = MAX_BITS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [31:0]       cfg_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              miso_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              sck_o,
  output logic              mosi_o,
  output logic              cs_no
);
  cfg_t              cfg_new, cfg_q, cfg_use;
  logic              go, edge_stb;
  logic [BIT_W-1:0]  nbits;
  logic [EDGE_W-1:0] nedges, edge_num;
  logic [CNT_W-1:0]  lead_cyc, trail_cyc, half_cyc;

  assign cfg_new = cfg_decode(cfg_i);
  assign go      = start_i && !busy_o;
  assign cfg_use = busy_o ? cfg_q : cfg_new;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  cfg_q <= '0;
    else if (go)  cfg_q <= cfg_new;
  end

  always_comb begin
    if (cfg_use.fsz < 4'd3) nbits = BIT_W'(4);
    else                    nbits = BIT_W'(cfg_use.fsz) + BIT_W'(1);
  end
  assign nedges = EDGE_W'({nbits, 1'b0});

  spi_cd_scale #(.PRE_W(PRE_W), .SC_W(SC_W), .CNT_W(CNT_W), .PRIME(1'b0)) u_lead (
    .pre_i(cfg_use.lead_pre), .sc_i(cfg_use.lead_sc), .cyc_o(lead_cyc));
  spi_cd_scale #(.PRE_W(PRE_W), .SC_W(SC_W), .CNT_W(CNT_W), .PRIME(1'b0)) u_trail (
    .pre_i(cfg_use.trail_pre), .sc_i(cfg_use.trail_sc), .cyc_o(trail_cyc));
  spi_cd_scale #(.PRE_W(PRE_W), .SC_W(SC_W), .CNT_W(CNT_W), .PRIME(1'b1)) u_baud (
    .pre_i(cfg_use.baud_pre), .sc_i(cfg_use.baud_sc), .cyc_o(half_cyc));

  spi_cd_timer #(.CNT_W(CNT_W), .EDGE_W(EDGE_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .go_i      (go),
    .cpol_i    (cfg_use.cpol),
    .lead_i    (lead_cyc),
    .trail_i   (trail_cyc),
    .half_i    (half_cyc),
    .edges_i   (nedges),
    .cs_n_o    (cs_no),
    .sck_o     (sck_o),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .edge_o    (edge_stb),
    .edge_num_o(edge_num)
  );

  spi_cd_shift #(.DATA_W(DATA_W), .EDGE_W(EDGE_W), .BIT_W(BIT_W), .IDX_W(IDX_W)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (go),
    .tx_i      (tx_data_i),
    .nbits_i   (nbits),
    .cpha_i    (cfg_use.cpha),
    .lsb_i     (cfg_use.lsb),
    .edge_i    (edge_stb),
    .edge_num_i(edge_num),
    .miso_i    (miso_i),
    .mosi_o    (mosi_o),
    .rx_o      (rx_data_o)
  );
endmodule

// File: rtl/spi_cd_master_chk.sv
module spi_cd_master_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic busy_o,
  input logic done_o,
  input logic sck_o,
  input logic cs_no
);
  a_r2_start_selects: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> busy_o && !cs_no);

  a_r3_no_early_sck: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |=> $stable(sck_o));

  a_r9_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r9_done_at_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> cs_no && !busy_o && $rose(cs_no));

  a_r11_sck_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no && $past(cs_no) |-> $stable(sck_o));
endmodule

bind spi_cs_delay_master spi_cd_master_chk u_chk (.*);

// File: tb/spi_cs_delay_master_tb.sv
`timescale 1ns/1ps
module spi_cs_delay_master_tb;
  logic        clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0, miso_i = 1'b0;
  logic [31:0] cfg_i = '0;
  logic [15:0] tx_data_i = '0;
  logic        busy_o, done_o, sck_o, mosi_o, cs_no;
  logic [15:0] rx_data_o;
  int n_chk = 0, n_fail = 0;

  always #2 clk_i = ~clk_i;

  spi_cs_delay_master u_dut (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int f_bits(input logic [31:0] c);
    return (c[30:27] < 3) ? 4 : int'(c[30:27]) + 1;
  endfunction
  function automatic int f_lead(input logic [31:0] c);
    return (2 * int'(c[23:22]) + 1) * (1 << (int'(c[15:12]) + 1));
  endfunction
  function automatic int f_trail(input logic [31:0] c);
    return (2 * int'(c[21:20]) + 1) * (1 << (int'(c[11:8]) + 1));
  endfunction
  function automatic int f_half(input logic [31:0] c);
    int b;
    case (c[17:16]) 2'd0: b = 2; 2'd1: b = 3; 2'd2: b = 5; default: b = 7; endcase
    return b * (1 << (int'(c[3:0]) + 1));
  endfunction
  function automatic int f_pos(input int j, input bit lsb, input int nb);
    return lsb ? j : nb - 1 - j;
  endfunction
  function automatic logic [31:0] mk(input int fsz, input bit cpol, input bit cpha, input bit lsb,
                                     input int lp, input int tp, input int bp,
                                     input int ls, input int ts, input int bs);
    logic [31:0] w = '0;
    w[30:27] = 4'(fsz); w[26] = cpol; w[25] = cpha; w[24] = lsb;
    w[23:22] = 2'(lp);  w[21:20] = 2'(tp); w[17:16] = 2'(bp);
    w[15:12] = 4'(ls);  w[11:8] = 4'(ts);  w[3:0] = 4'(bs);
    return w;
  endfunction

  task automatic xfer(input logic [31:0] cfg, input logic [15:0] tx, input logic [15:0] sw,
                      input bit disturb);
    int nb = f_bits(cfg);
    int lead = f_lead(cfg), trail = f_trail(cfg), half = f_half(cfg);
    bit cpol = cfg[26], cpha = cfg[25], lsb = cfg[24];
    int cyc = 0, edges = 0, first = -1, last = -1, bad_gap = 0, rise = -1;
    int done_cyc = -1, dcount = 0;
    int limit = lead + trail + 2 * nb * half + 20;
    logic prev_sck;
    logic [15:0] mosi_w = '0;
    logic [15:0] mask = 16'((32'd1 << nb) - 1);
    logic [15:0] rx_keep;

    @(negedge clk_i);
    cfg_i = cfg; tx_data_i = tx; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0; cyc = 1;
    chk(cs_no == 1'b0 && busy_o == 1'b1, "R2 select on start", cs_no, 0);
    chk(sck_o == cpol, "R2 idle level", sck_o, cpol);
    miso_i = sw[f_pos(0, lsb, nb)];
    prev_sck = sck_o;
    while (cyc < limit) begin
      @(negedge clk_i);
      cyc++;
      if (disturb && cyc == 2) begin
        start_i = 1'b1; cfg_i = ~cfg; tx_data_i = ~tx;
      end
      if (disturb && cyc == 4) start_i = 1'b0;
      if (done_o) begin dcount++; if (done_cyc < 0) done_cyc = cyc; end
      if (cs_no) begin rise = cyc; break; end
      if (sck_o != prev_sck) begin
        edges++;
        if (first < 0) first = cyc;
        else if (cyc - last != half) bad_gap++;
        last = cyc;
        prev_sck = sck_o;
        if (!cpha) begin
          if (edges % 2 == 1) mosi_w[f_pos((edges - 1) / 2, lsb, nb)] = mosi_o;
          else if (edges / 2 < nb) miso_i = sw[f_pos(edges / 2, lsb, nb)];
        end else begin
          if (edges % 2 == 1) miso_i = sw[f_pos((edges - 1) / 2, lsb, nb)];
          else mosi_w[f_pos(edges / 2 - 1, lsb, nb)] = mosi_o;
        end
      end
    end
    chk(first - 1 == lead, "R3 setup delay", first - 1, lead);
    chk(rise - last == trail, "R4 hold delay", rise - last, trail);
    chk(bad_gap == 0, "R5 edge spacing", bad_gap, 0);
    chk(edges == 2 * nb, "R6 edge count", edges, 2 * nb);
    chk(sck_o == cpol, "R6 final level", sck_o, cpol);
    chk(mosi_w == (tx & mask), "R7 R8 mosi word", mosi_w, tx & mask);
    chk(rx_data_o == (sw & mask), "R7 R8 rx word", rx_data_o, sw & mask);
    chk(done_cyc == rise && dcount == 1 && busy_o == 1'b0, "R9 done at release", done_cyc, rise);
    rx_keep = rx_data_o;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      chk(done_o == 1'b0 && rx_data_o == rx_keep, "R9 pulse and hold", done_o, 0);
      chk(cs_no == 1'b1 && sck_o == cpol, "R11 quiet when idle", sck_o, cpol);
      if (disturb) chk(busy_o == 1'b0, "R10 no restart", busy_o, 0);
    end
    if (disturb) chk(rx_data_o == (sw & mask), "R10 latched config used", rx_data_o, sw & mask);
    cfg_i = '0; tx_data_i = '0;
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h1c5_0a17));
    repeat (3) @(negedge clk_i);
    chk(cs_no == 1'b1, "R1 cs idle", cs_no, 1);
    chk(sck_o == 1'b0, "R1 sck idle", sck_o, 0);
    chk(busy_o == 1'b0 && done_o == 1'b0, "R1 flags idle", busy_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    xfer(mk(3, 1'b1, 1'b1, 1'b0, 0, 0, 0, 0, 0, 0), 16'h000a, 16'h0005, 1'b0);
    xfer(mk(15, 1'b0, 1'b0, 1'b1, 1, 2, 1, 1, 2, 0), 16'hc35a, 16'h9e17, 1'b0);
    xfer(mk(1, 1'b0, 1'b1, 1'b1, 0, 1, 0, 0, 0, 1), 16'hfff6, 16'hfff9, 1'b0);
    xfer(mk(7, 1'b1, 1'b0, 1'b0, 3, 0, 2, 10, 0, 0), 16'h00b4, 16'h004d, 1'b0);
    xfer(mk(7, 1'b0, 1'b1, 1'b0, 0, 3, 3, 0, 9, 4), 16'h0066, 16'h0099, 1'b0);
    xfer(mk(11, 1'b1, 1'b1, 1'b1, 2, 1, 1, 2, 1, 1), 16'h0abc, 16'h0543, 1'b1);

    for (int i = 0; i < 24; i++) begin
      int fsz = ($urandom % 6 == 0) ? int'($urandom % 3) : 3 + int'($urandom % 13);
      xfer(mk(fsz, 1'($urandom), 1'($urandom), 1'($urandom),
              int'($urandom % 4), int'($urandom % 4), int'($urandom % 4),
              int'($urandom % 4), int'($urandom % 4), int'($urandom % 3)),
           16'($urandom), 16'($urandom), 1'b0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule